// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller with Change

This block runs a single-item vending machine whose item costs one rupee. Each clock it may take one coin, named by a two-bit code and qualified by a valid strobe. It adds the coin's worth to a running total, counted in units of 25 paise. When the total reaches or passes the price, the block raises a dispense pulse for one cycle, clears the total and pays back any surplus as a coded balance with its own valid strobe.

Paying one rupee in exact coins gives a dispense with no balance. A surplus of 25 or 50 paise is paid back in the dispense cycle. A surplus of 75 paise has no single balance code, so it is paid back over two cycles: 50 paise first, then 25 paise. While that split payback is in progress, the coin input is ignored. The reset is asynchronous and active low. The block synchronises the release of reset to its clock.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `dispense` and `bal_valid` read 0, `bal_code` reads 00 and the stored total is zero. Proof of a zero total: a lone 75 paise coin after reset gives no dispense.
- R2: Coin codes carry these values: 00 is 25 paise, 01 is 50 paise, 10 is 75 paise and 11 is one rupee (1 to 4 units).
- R3: A coin is counted only at a clock edge where `coin_valid` is high. At other edges `coin_code` has no effect on the total or the outputs.
- R4: Take the clock edge at which an accepted coin brings the total to 4 units or more. In the next cycle `dispense` is 1, for that one cycle.
- R5: Totals below the price are kept from coin to coin. The total returns to zero in the cycle in which `dispense` is issued.
- R6: In the dispense cycle the balance is paid back as follows. A surplus of 25 paise gives `bal_valid`=1 with `bal_code`=01. A surplus of 50 paise gives `bal_valid`=1 with `bal_code`=10. An exact payment gives `bal_valid`=0.
- R7: A surplus of 75 paise gives `bal_code`=10 with `bal_valid`=1 in the dispense cycle. In the next cycle it gives `bal_code`=01 with `bal_valid`=1 and `dispense`=0.
- R8: A valid coin presented at the clock edge that ends the first half of a split payback is ignored. It does not count toward the next sale.
- R9: `bal_code` reads 00 whenever `bal_valid` is 0. Code 11 (one rupee) is reserved and never issued, because the surplus never exceeds 75 paise.
- R10: Driving `rst_n` low clears `dispense` and `bal_valid` at once, with no clock edge needed. After `rst_n` rises, the block stays in reset for two more clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coin_code | input | 2 | Coin value code |
| coin_valid | input | 1 | Qualifies `coin_code` in this cycle |
| dispense | output | 1 | One-cycle pulse that releases the item |
| bal_code | output | 2 | Balance value code: 01 is 25 paise, 10 is 50 paise |
| bal_valid | output | 1 | Qualifies `bal_code` |

## Verification
The assertions take three things for granted. First, `coin_valid` is a clean synchronous strobe, so each high cycle is exactly one coin. Second, `coin_code` is meaningful only while that strobe is high. Third, a coin offered during the first half of a 75 paise payback is lost on purpose, not held over. The stimulus keeps to these rules. It drives coins on the falling edge and puts idle cycles between most coins, with random junk on `coin_code` while the strobe is low. It offers a coin during a split payback only in the directed case that checks this coin is lost.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int CODE_W   = 2;
  localparam int PRICE_U  = 4;
  localparam int TOT_W    = $clog2(PRICE_U);
  localparam int SUM_W    = $clog2(2 * PRICE_U);

  typedef enum logic [CODE_W-1:0] {
    BAL_NONE = 2'b00,
    BAL_QTR  = 2'b01,
    BAL_HALF = 2'b10,
    BAL_RUP  = 2'b11
  } bal_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_TAIL = 1'b1
  } chg_st_e;

  function automatic logic [SUM_W-1:0] coin_units(input logic [CODE_W-1:0] code);
    return SUM_W'(code) + SUM_W'(1);
  endfunction
endpackage

// File: rtl/vend_rst_sync.sv
module vend_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
(
  input  logic [CODE_W-1:0] coin_code,
  input  logic              coin_valid,
  input  logic              hold,
  output logic              take,
  output logic [SUM_W-1:0]  units
);
  always_comb begin
    take  = coin_valid && !hold;
    units = coin_units(coin_code);
  end
endmodule

// File: rtl/vend_accum.sv
module vend_accum
  import vend_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [SUM_W-1:0] units,
  output logic             sale,
  output logic [SUM_W-1:0] excess
);
  logic [TOT_W-1:0] total_q, total_d;
  logic [SUM_W-1:0] sum;
  logic             tot_en;

  always_comb begin
    sum     = SUM_W'(total_q) + units;
    sale    = take && (sum >= SUM_W'(PRICE_U));
    excess  = sale ? (sum - SUM_W'(PRICE_U)) : '0;
    tot_en  = take;
    total_d = sale ? '0 : sum[TOT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      total_q <= '0;
    else if (tot_en) total_q <= total_d;
  end

  AST_IDLE_KEEPS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(total_q)); // R3
  AST_SALE_CLEARS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    sale |=> (total_q == '0)); // R5
endmodule

// File: rtl/vend_change_fsm.sv
module vend_change_fsm
  import vend_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sale,
  input  logic [SUM_W-1:0] excess,
  output logic             dispense,
  output logic [CODE_W-1:0] bal_code,
  output logic             bal_valid,
  output logic             hold
);
  chg_st_e st_q, st_d;
  logic    disp_q, disp_d;
  bal_e    code_q, code_d;
  logic    bv_q, bv_d;

  always_comb begin
    st_d   = ST_RUN;
    disp_d = 1'b0;
    code_d = BAL_NONE;
    bv_d   = 1'b0;
    if (st_q == ST_TAIL) begin
      code_d = BAL_QTR;
      bv_d   = 1'b1;
    end else if (sale) begin
      disp_d = 1'b1;
      case (excess)
        SUM_W'(1): begin code_d = BAL_QTR;  bv_d = 1'b1; end
        SUM_W'(2): begin code_d = BAL_HALF; bv_d = 1'b1; end
        SUM_W'(3): begin code_d = BAL_HALF; bv_d = 1'b1; st_d = ST_TAIL; end
        default:   begin code_d = BAL_NONE; bv_d = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      disp_q <= 1'b0;
      code_q <= BAL_NONE;
      bv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      disp_q <= disp_d;
      code_q <= code_d;
      bv_q   <= bv_d;
    end
  end

  assign dispense  = disp_q;
  assign bal_code  = code_q;
  assign bal_valid = bv_q;
  assign hold      = (st_q == ST_TAIL);

  AST_SALE_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sale |=> dispense); // R4
  AST_TAIL_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TAIL) |-> (dispense && bal_valid && bal_code == BAL_HALF)); // R7
  AST_TAIL_SECOND_QTR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TAIL) |=> (!dispense && bal_valid && bal_code == BAL_QTR)); // R7
  AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !bal_valid |-> (bal_code == BAL_NONE)); // R9
  AST_NO_RUPEE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    bal_valid |-> (bal_code != BAL_RUP)); // R9
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] coin_code,
  input  logic              coin_valid,
  output logic              dispense,
  output logic [CODE_W-1:0] bal_code,
  output logic              bal_valid
);
  logic             rst_n_s;
  logic             hold;
  logic             take;
  logic [SUM_W-1:0] units;
  logic             sale;
  logic [SUM_W-1:0] excess;

  vend_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  vend_coin_decode u_dec (
    .coin_code  (coin_code),
    .coin_valid (coin_valid),
    .hold       (hold),
    .take       (take),
    .units      (units)
  );

  vend_accum u_acc (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .take   (take),
    .units  (units),
    .sale   (sale),
    .excess (excess)
  );

  vend_change_fsm u_chg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sale      (sale),
    .excess    (excess),
    .dispense  (dispense),
    .bal_code  (bal_code),
    .bal_valid (bal_valid),
    .hold      (hold)
  );

  AST_DISP_AFTER_COIN: assert property (@(posedge clk) disable iff (!rst_n_s)
    dispense |-> $past(coin_valid)); // R3
  AST_TAIL_BLOCKS_COIN: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hold && coin_valid) |=> (bal_code == BAL_QTR && !dispense)); // R8
endmodule

// File: tb/vend_ctrl_bench.sv
module vend_ctrl_bench;
  logic       clk;
  logic       rst_n;
  logic [1:0] coin_code;
  logic       coin_valid;
  logic       dispense;
  logic [1:0] bal_code;
  logic       bal_valid;

  int checks;
  int failures;
  bit done;

  int m_total;
  bit m_tail;

  vend_ctrl u_vend_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .coin_code  (coin_code),
    .coin_valid (coin_valid),
    .dispense   (dispense),
    .bal_code   (bal_code),
    .bal_valid  (bal_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int units_of(input logic [1:0] c);
    return int'(c) + 1;
  endfunction

  function automatic logic [1:0] quarter_code(input int ex);
    if (ex == 1)      return 2'b01;
    else if (ex >= 2) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check3(input string req, input logic ed, input logic ev, input logic [1:0] ec);
    checks++;
    if (dispense !== ed || bal_valid !== ev || bal_code !== ec) begin
      failures++;
      $display("FAIL %s: got disp=%b bv=%b bc=%b expected disp=%b bv=%b bc=%b",
               req, dispense, bal_valid, bal_code, ed, ev, ec);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] c, input string tag);
    logic ed, ev;
    logic [1:0] ec;
    string req;
    ed = 1'b0; ev = 1'b0; ec = 2'b00; req = "R3";
    if (m_tail) begin
      ev = 1'b1; ec = 2'b01; m_tail = 1'b0; req = v ? "R8" : "R7";
    end else if (v) begin
      int s;
      s = m_total + units_of(c);
      if (s >= 4) begin
        ed = 1'b1;
        ev = (s > 4);
        ec = quarter_code(s - 4);
        m_tail = (s - 4 == 3);
        m_total = 0;
        req = (s == 4) ? "R4" : (s == 7) ? "R7" : "R6";
      end else begin
        m_total = s;
        req = "R5";
      end
    end
    if (tag != "") req = tag;
    coin_valid = v;
    coin_code  = c;
    @(posedge clk);
    #2;
    check3(req, ed, ev, ec);
    @(negedge clk);
    coin_valid = 1'b0;
    coin_code  = 2'($urandom_range(0, 3));
  endtask

  initial begin
    void'($urandom(32'd7721));
    checks = 0; failures = 0; done = 1'b0;
    m_total = 0; m_tail = 1'b0;
    rst_n = 1'b0; coin_valid = 1'b0; coin_code = 2'b00;
    repeat (3) @(negedge clk);
    check3("R1", 1'b0, 1'b0, 2'b00);
    rst_n = 1'b1;
    // R10: held in reset two edges after release; a coin now is dropped
    coin_valid = 1'b1; coin_code = 2'b11;
    @(posedge clk); #2; check3("R10", 1'b0, 1'b0, 2'b00);
    @(negedge clk); coin_valid = 1'b0;
    repeat (2) step(1'b0, 2'b00, "R1");
    // R1: a lone 75 paise coin after reset does not sell
    step(1'b1, 2'b10, "R1");
    step(1'b0, 2'b11, "R3");
    step(1'b1, 2'b00, "R5");
    // R2: each code alone and combined
    step(1'b1, 2'b11, "R2");
    step(1'b1, 2'b01, "R2");
    step(1'b1, 2'b01, "R2");
    step(1'b1, 2'b00, "R2");
    step(1'b1, 2'b10, "R2");
    // every total 25..175 paise: pre-load then one coin, idle gaps
    for (int pre = 0; pre < 4; pre++) begin
      for (int c = 0; c < 4; c++) begin
        for (int k = 0; k < pre; k++) begin
          step(1'b1, 2'b00, "R5");
          step(1'b0, 2'($urandom_range(0, 3)), "R3");
        end
        step(1'b1, 2'(c), "");
        step(1'b0, 2'($urandom_range(0, 3)), "");
        if (m_total != 0) begin
          for (int k = 0; k < 4; k++) if (m_total != 0) step(1'b1, 2'b00, "");
          step(1'b0, 2'b00, "");
        end
      end
    end
    // R8: coin offered during first half of split payback is lost
    step(1'b1, 2'b10, "R5");
    step(1'b1, 2'b11, "R7");
    step(1'b1, 2'b11, "R8");
    step(1'b1, 2'b10, "R8");
    step(1'b1, 2'b00, "R8");
    step(1'b0, 2'b00, "R9");
    // R10: asynchronous clear during a dispense cycle
    coin_valid = 1'b1; coin_code = 2'b11;
    @(posedge clk); #2;
    check3("R4", 1'b1, 1'b0, 2'b00);
    rst_n = 1'b0; #1;
    check3("R10", 1'b0, 1'b0, 2'b00);
    @(negedge clk); coin_valid = 1'b0; rst_n = 1'b1;
    m_total = 0; m_tail = 1'b0;
    repeat (3) step(1'b0, 2'b00, "R10");
    step(1'b1, 2'b10, "R1");
    step(1'b1, 2'b00, "R4");
    // constrained random
    for (int i = 0; i < 600; i++) begin
      step(($urandom_range(0, 99) < 35), 2'($urandom_range(0, 3)), "");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule